// File: doc/BRIEF.md
# Reset Pin Glitch Filter

This block turns a noisy, active-low external reset pin into a clean internal reset. The pin first passes through a two-stage synchronizer. When the digital filter is selected and usable, the synchronized pin is examined on each sampling strobe. A reset is accepted only after the pin has read low on a run of consecutive samples. The accepted level then passes through a delay stage. That stage stands in for the analog noise eliminator and is counted in cycles of the free-running clock.

If the select bit is clear, the digital filter is skipped and only the delay stage is used. The filter is also skipped automatically while the sampling clock cannot be trusted. That covers stop mode, the oscillator settling time after a wake-up, and operation from the slow subclock. When an internal reset takes effect, the select bit clears itself, so the delay-only path stays selected. Release does not wait for a run of high samples. The internal reset lifts one delay period after the pin goes high again.

The sampling clock is represented by `sampleTick`, a one-cycle strobe in the `clk` domain. `SAMPLES_N` sets the run length. `DELAY_CYC` sets the delay stage length.

Top module: `rst_glitch_filter`

## Requirements
- R1: After power-on reset (`porN` low), `intRstN` is 1 and `selQ` is 0.
- R2: With `selQ` = 0, a pin driven low and held is seen as `intRstN` = 0 exactly 2 + `DELAY_CYC` rising `clk` edges after the change. The 2 edges are the synchronizer stages.
- R3: When the pin returns high, `intRstN` returns to 1 exactly 2 + `DELAY_CYC` edges later. No run of high samples is needed.
- R4: With the filter active, a low pulse that covers fewer than `SAMPLES_N` − 1 sampling strobes never drives `intRstN` low.
- R5: With the filter active, a low level held across `SAMPLES_N` consecutive strobes asserts `intRstN` = 0.
- R6: With the filter active, a strobe that samples the pin high restarts the run. Two partial low runs that are each too short are rejected even if they add up to more than `SAMPLES_N` strobes.
- R7: While the internal reset is asserted, `selQ` reads 0.
- R8: A write of 1 to the select bit while the internal reset is asserted has no effect, so `selQ` stays 0. The clear has priority in the same cycle.
- R9: While `stopMode` or `oscStab` is 1, the digital filter is bypassed. A low pulse too short for the filter, but longer than the delay, then asserts `intRstN`.
- R10: While `subclkMode` is 1, the digital filter is bypassed in the same way.
- R11: A synchronized level change that reverts within fewer than `DELAY_CYC` cycles never reaches `intRstN`.
- R12: Without an active reset, a pulse on `selWrEn` loads `selWrData` into `selQ`, which shows the new value one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock for the synchronizer, counters and delay stage |
| porN | input | 1 | Asynchronous power-on reset, active low |
| rstPinN | input | 1 | Raw external reset pin, active low |
| sampleTick | input | 1 | One-cycle strobe marking each sampling clock edge |
| selWrEn | input | 1 | Write strobe for the filter select bit |
| selWrData | input | 1 | Value written to the select bit |
| stopMode | input | 1 | Stop mode is active |
| subclkMode | input | 1 | Running from the subclock |
| oscStab | input | 1 | Oscillator stabilization period in progress |
| intRstN | output | 1 | Filtered internal reset, active low |
| selQ | output | 1 | Current state of the filter select bit |

## Verification
Two events can fall in the same cycle: a software write that sets the select bit, and the self-clear caused by an active internal reset. The bench holds a long low pulse until the internal reset is asserted. It then strobes a write of 1 while that reset is still held. The scoreboard expects `selQ` to stay 0 on the following cycle and for the rest of the reset, which judges the clear as taking priority over the write.

// File: rtl/rst_glitch_filter_pkg.sv
package rst_glitch_filter_pkg;
  typedef struct packed {
    logic digitalOn;  // digital run counter is in use
    logic bypass;     // sampling clock unusable, forced delay-only path
  } filtCtrl_t;
endpackage

// File: rtl/rst_filter_ctrl.sv
module rst_filter_ctrl
  import rst_glitch_filter_pkg::*;
(
  input  logic      clk,
  input  logic      porN,
  input  logic      selWrEn,
  input  logic      selWrData,
  input  logic      stopMode,
  input  logic      subclkMode,
  input  logic      oscStab,
  input  logic      rstActive,
  output filtCtrl_t ctrl,
  output logic      selQ
);
  logic selReg;

  // an internal reset wipes the select bit; it outranks a software write
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)          selReg <= 1'b0;
    else if (rstActive) selReg <= 1'b0;
    else if (selWrEn)   selReg <= selWrData;
  end

  always_comb begin
    ctrl.bypass    = stopMode | subclkMode | oscStab;
    ctrl.digitalOn = selReg & ~ctrl.bypass;
  end

  assign selQ = selReg;

  AST_SEL_CLEARED: assert property (@(posedge clk) disable iff (!porN)
    rstActive |=> !selQ); // R7
  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!porN)
    (selWrEn && !rstActive) |=> (selQ == $past(selWrData))); // R12
  AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!porN)
    (selWrEn && selWrData && rstActive) |=> !selQ); // R8
endmodule

// File: rtl/rst_filter_datapath.sv
module rst_filter_datapath
  import rst_glitch_filter_pkg::*;
#(
  parameter int SAMPLES_N = 20,
  parameter int DELAY_CYC = 8
) (
  input  logic      clk,
  input  logic      porN,
  input  logic      rstPinN,
  input  logic      sampleTick,
  input  filtCtrl_t ctrl,
  output logic      rstActive
);
  localparam int CNT_W = $clog2(SAMPLES_N + 1);
  localparam int DLY_W = $clog2(DELAY_CYC + 1);
  localparam logic [CNT_W-1:0] RUN_FULL = CNT_W'(SAMPLES_N);
  localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(DELAY_CYC - 1);

  logic             syncA, syncPin;
  logic [CNT_W-1:0] runCnt;
  logic [DLY_W-1:0] dlyCnt;
  logic             filtLow;
  logic             mismatch;

  // two-flop synchronizer, idles high (pin released)
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      syncA   <= 1'b1;
      syncPin <= 1'b1;
    end else begin
      syncA   <= rstPinN;
      syncPin <= syncA;
    end
  end

  // run counter of consecutive low samples, saturating at SAMPLES_N
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                    runCnt <= '0;
    else if (!ctrl.digitalOn)     runCnt <= '0;
    else if (sampleTick) begin
      if (syncPin)                runCnt <= '0;
      else if (runCnt != RUN_FULL) runCnt <= runCnt + 1'b1;
    end
  end

  always_comb begin
    if (ctrl.digitalOn) filtLow = (runCnt == RUN_FULL);
    else                filtLow = ~syncPin;
    mismatch = (filtLow != rstActive);
  end

  // delay stage: a level must persist DELAY_CYC cycles to pass
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      dlyCnt    <= '0;
      rstActive <= 1'b0;
    end else if (!mismatch) begin
      dlyCnt <= '0;
    end else if (dlyCnt == DLY_LAST) begin
      dlyCnt    <= '0;
      rstActive <= filtLow;
    end else begin
      dlyCnt <= dlyCnt + 1'b1;
    end
  end

  AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!porN)
    runCnt <= RUN_FULL); // R5
  AST_HIGH_RESTARTS: assert property (@(posedge clk) disable iff (!porN)
    (sampleTick && syncPin) |=> (runCnt == '0)); // R6
  AST_BYPASS_IDLE: assert property (@(posedge clk) disable iff (!porN)
    ctrl.bypass |=> (runCnt == '0)); // R9
  AST_DELAY_FULL: assert property (@(posedge clk) disable iff (!porN)
    !$stable(rstActive) |-> ($past(dlyCnt) == DLY_LAST)); // R3
endmodule

// File: rtl/rst_glitch_filter.sv
module rst_glitch_filter
  import rst_glitch_filter_pkg::*;
#(
  parameter int SAMPLES_N = 20,
  parameter int DELAY_CYC = 8
) (
  input  logic clk,
  input  logic porN,
  input  logic rstPinN,
  input  logic sampleTick,
  input  logic selWrEn,
  input  logic selWrData,
  input  logic stopMode,
  input  logic subclkMode,
  input  logic oscStab,
  output logic intRstN,
  output logic selQ
);
  filtCtrl_t ctrl;
  logic      rstActive;

  rst_filter_ctrl uCtrl (
    .clk(clk), .porN(porN), .selWrEn(selWrEn), .selWrData(selWrData),
    .stopMode(stopMode), .subclkMode(subclkMode), .oscStab(oscStab),
    .rstActive(rstActive), .ctrl(ctrl), .selQ(selQ)
  );

  rst_filter_datapath #(.SAMPLES_N(SAMPLES_N), .DELAY_CYC(DELAY_CYC)) uData (
    .clk(clk), .porN(porN), .rstPinN(rstPinN), .sampleTick(sampleTick),
    .ctrl(ctrl), .rstActive(rstActive)
  );

  assign intRstN = ~rstActive;

  AST_OUT_RESET_IDLE: assert property (@(posedge clk) disable iff (!porN)
    $fell(intRstN) |=> !selQ); // R7
endmodule

// File: tb/tb_rst_glitch_filter.sv
module tb_rst_glitch_filter;
  localparam int N   = 6;
  localparam int DLY = 5;
  localparam int SPER = 4;

  logic clk = 1'b0;
  logic porN = 1'b0, rstPinN = 1'b1, sampleTick = 1'b0;
  logic selWrEn = 1'b0, selWrData = 1'b0;
  logic stopMode = 1'b0, subclkMode = 1'b0, oscStab = 1'b0;
  logic intRstN, selQ;

  int cyc = 0;
  int checks = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    int    at;
    bit    isSel;
    bit    val;
    string tag;
  } expItem_t;
  expItem_t q[$];

  rst_glitch_filter #(.SAMPLES_N(N), .DELAY_CYC(DLY)) dut (
    .clk(clk), .porN(porN), .rstPinN(rstPinN), .sampleTick(sampleTick),
    .selWrEn(selWrEn), .selWrData(selWrData), .stopMode(stopMode),
    .subclkMode(subclkMode), .oscStab(oscStab), .intRstN(intRstN), .selQ(selQ)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) sampleTick <= ((cyc + 1) % SPER == 0);

  // driver side: queue an expectation some cycles ahead of now
  task automatic expectAt(input int ofs, input bit isSel, input bit val, input string tag);
    expItem_t it;
    it.at = cyc + ofs; it.isSel = isSel; it.val = val; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic expectSpan(input int fromOfs, input int toOfs, input bit val, input string tag);
    for (int i = fromOfs; i <= toOfs; i++) expectAt(i, 1'b0, val, tag);
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    waitCyc(2);
  endtask

  task automatic writeSel(input bit v);
    selWrEn = 1'b1; selWrData = v;
    waitCyc(1);
    selWrEn = 1'b0;
  endtask

  // monitor: compare due items away from the active edge
  always @(negedge clk) begin
    while (q.size() != 0 && q[0].at <= cyc) begin
      expItem_t it;
      logic act;
      it = q.pop_front();
      act = it.isSel ? selQ : intRstN;
      checks++;
      if (it.at != cyc || act !== it.val) begin
        bad++;
        $display("FAIL %s %s act=%b exp=%b at=%0d now=%0d", it.tag,
                 it.isSel ? "selQ" : "intRstN", act, it.val, it.at, cyc);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++;
      checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    waitCyc(3);
    porN = 1'b1;
    // R1 reset state
    expectAt(1, 1'b0, 1'b1, "R1");
    expectAt(1, 1'b1, 1'b0, "R1");
    drain();

    // R2 / R3: delay-only path, exact latency both ways
    rstPinN = 1'b0;
    expectAt(1 + DLY, 1'b0, 1'b1, "R2");
    expectAt(2 + DLY, 1'b0, 1'b0, "R2");
    waitCyc(20);
    rstPinN = 1'b1;
    expectAt(1 + DLY, 1'b0, 1'b0, "R3");
    expectAt(2 + DLY, 1'b0, 1'b1, "R3");
    drain();

    // R11: glitch shorter than the delay is absorbed
    rstPinN = 1'b0;
    waitCyc(3);
    rstPinN = 1'b1;
    expectSpan(1, 12, 1'b1, "R11");
    drain();

    // R12: select write lands next cycle
    selWrEn = 1'b1; selWrData = 1'b1;
    expectAt(1, 1'b1, 1'b1, "R12");
    waitCyc(1);
    selWrEn = 1'b0;
    drain();

    // R4: short pulse with filter active is rejected
    rstPinN = 1'b0;
    expectSpan(1, (N - 2) * SPER + DLY + 6, 1'b1, "R4");
    waitCyc((N - 2) * SPER);
    rstPinN = 1'b1;
    drain();
    expectAt(1, 1'b1, 1'b1, "R4");
    drain();

    // R6: two partial runs split by high samples are rejected
    rstPinN = 1'b0;
    expectSpan(1, 2 * (N - 2) * SPER + 2 * SPER + DLY + 6, 1'b1, "R6");
    waitCyc((N - 2) * SPER);
    rstPinN = 1'b1;
    waitCyc(2 * SPER);
    rstPinN = 1'b0;
    waitCyc((N - 2) * SPER);
    rstPinN = 1'b1;
    drain();

    // R5 / R7 / R8 / R3: long pulse accepted, select self-clears, write blocked
    rstPinN = 1'b0;
    expectAt((N + 4) * SPER - 4, 1'b0, 1'b0, "R5");
    expectAt((N + 4) * SPER - 4, 1'b1, 1'b0, "R7");
    waitCyc((N + 4) * SPER - 4);
    selWrEn = 1'b1; selWrData = 1'b1;  // collides with the internal clear
    expectAt(1, 1'b1, 1'b0, "R8");
    expectAt(3, 1'b1, 1'b0, "R8");
    waitCyc(1);
    selWrEn = 1'b0;
    waitCyc(3);
    rstPinN = 1'b1;
    expectAt(1 + DLY, 1'b0, 1'b0, "R3");
    expectAt(2 + DLY, 1'b0, 1'b1, "R3");
    drain();

    // R9: stop mode bypasses the filter
    writeSel(1'b1);
    stopMode = 1'b1;
    rstPinN = 1'b0;
    expectAt(2 + DLY, 1'b0, 1'b0, "R9");
    expectAt(3 + DLY, 1'b1, 1'b0, "R9");
    waitCyc((N - 2) * SPER);
    rstPinN = 1'b1;
    drain();
    stopMode = 1'b0;
    waitCyc(2);

    // R9: oscillator settling bypasses the filter
    writeSel(1'b1);
    oscStab = 1'b1;
    rstPinN = 1'b0;
    expectAt(2 + DLY, 1'b0, 1'b0, "R9");
    waitCyc((N - 2) * SPER);
    rstPinN = 1'b1;
    drain();
    oscStab = 1'b0;
    waitCyc(2);

    // R10: subclock operation bypasses the filter
    writeSel(1'b1);
    subclkMode = 1'b1;
    rstPinN = 1'b0;
    expectAt(2 + DLY, 1'b0, 1'b0, "R10");
    expectAt(3 + DLY, 1'b1, 1'b0, "R10");
    waitCyc((N - 2) * SPER);
    rstPinN = 1'b1;
    expectAt(2 + DLY, 1'b0, 1'b1, "R10");
    drain();
    subclkMode = 1'b0;

    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule